// File: doc/BRIEF.md
# Multiplexed LCD Common Scan Timer

This block generates the row-scan timing for a character dot-matrix LCD with up to sixteen common lines and forty segment columns. It runs on the oscillator clock and steps a one-hot common select through the active rows, holding each row for a fixed dwell. During each dwell it emits a burst of shift-clock pulses, one per segment bit, so that the column data for the next row can be clocked into a serial shift register. At the end of the dwell it pulses a latch strobe that moves that data into the segment latch as the next common is selected. Cascaded column extenders can follow the same scan because they are driven by the same shift and latch pulses.

Two mode bits choose the duty. Two-line operation scans sixteen rows with a short dwell. One-line operation scans eight rows, or eleven rows when the tall font is chosen, and each of those rows gets a long dwell. A polarity-alternation output flips once per frame so that the panel sees an AC drive, and a frame-start pulse marks the first clock of row 0. Mode changes are deferred to the next frame boundary so that a frame is never cut short. The block carries no data stream, only timing, so it has no valid/ready handshake: every pin is a plain level or pulse.

Top module: `lcd_scan_timer`

## Requirements
- R1: With `two_line`=1 the scan covers 16 rows (com_sel bits 0 to 15) of DWELL_SHORT clocks each, and `tall_font` has no effect; a frame lasts 16*DWELL_SHORT clocks.
- R2: With `two_line`=0 and `tall_font`=0 the scan covers 8 rows of DWELL_LONG clocks each; a frame lasts 8*DWELL_LONG clocks.
- R3: With `two_line`=0 and `tall_font`=1 the scan covers 11 rows of DWELL_LONG clocks each; a frame lasts 11*DWELL_LONG clocks.
- R4: Rows are visited in ascending order from row 0; while row r is selected, `com_sel` equals a one in bit r only, and never more than one bit is high.
- R5: While `disp_en`=0, `com_sel` is all zeros in that same cycle, and the scan keeps counting, so re-enabling resumes at the position the scan would have reached anyway.
- R6: Counting the clocks of a row dwell from 0, `shift_clk` is high on the odd counts below 2*SEG_BITS and low on every other count, which gives SEG_BITS pulses per row.
- R7: `latch_stb` is high for exactly one clock, the last clock of every row's dwell, and the next clock is count 0 of the following row.
- R8: `frame_start` is high for exactly the first clock of row 0 (count 0), once per frame.
- R9: `alt_pol` is 0 after reset and inverts exactly once per frame, in the first clock of the new frame.
- R10: The mode bits are sampled only on the last clock of a frame; a change made mid-frame leaves the current frame's row count and dwell untouched, and the next frame starts at row 0 in the new mode.
- R11: During and straight after reset the scan sits at row 0, count 0, in the 16-row mode, with `alt_pol`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_en | input | 1 | Display enable; low blanks all commons |
| two_line | input | 1 | 1 selects the 16-row scan |
| tall_font | input | 1 | In one-line mode, 1 selects the 11-row scan |
| com_sel | output | ROWS_2L | One-hot common select, bit r for row r |
| shift_clk | output | 1 | Segment serial shift clock |
| latch_stb | output | 1 | Segment latch strobe, last clock of each row |
| alt_pol | output | 1 | Drive polarity alternation, toggles per frame |
| frame_start | output | 1 | One-clock pulse on the first clock of row 0 |

## Verification
The bench builds the block with SEG_BITS=6, DWELL_LONG=40 and DWELL_SHORT=20, and keeps the row counts at 16, 11 and 8. The short dwells make a full frame last a few hundred clocks, so every mode, several frame wraps, alternation toggles and mid-frame mode changes are compared clock by clock against an independent model of the scan position. The shift burst still ends well inside the shortest dwell, so the gap between the last shift pulse and the latch strobe is exercised as well.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    SCAN_ROWS8  = 2'd0,
    SCAN_ROWS11 = 2'd1,
    SCAN_ROWS16 = 2'd2
  } scan_mode_e;

  // Two-line operation always takes the 16-row scan; font only matters in one-line mode.
  function automatic scan_mode_e pick_mode(input logic two_line, input logic tall_font);
    if (two_line)       return SCAN_ROWS16;
    else if (tall_font) return SCAN_ROWS11;
    else                return SCAN_ROWS8;
  endfunction

endpackage

// File: rtl/lcd_scan_mode.sv
module lcd_scan_mode
  import lcd_scan_pkg::*;
#(
  parameter int ROWS_2L     = 16,
  parameter int ROWS_TALL   = 11,
  parameter int ROWS_SHORT  = 8,
  parameter int DWELL_LONG  = 400,
  parameter int DWELL_SHORT = 200,
  parameter int ROW_W       = 4,
  parameter int CNT_W       = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             two_line,
  input  logic             tall_font,
  input  logic             frame_wrap,
  output logic [ROW_W-1:0] rows_m1,
  output logic [CNT_W-1:0] dwell_m1
);

  localparam logic [ROW_W-1:0] LAST_2L    = ROW_W'(ROWS_2L - 1);
  localparam logic [ROW_W-1:0] LAST_TALL  = ROW_W'(ROWS_TALL - 1);
  localparam logic [ROW_W-1:0] LAST_SHORT = ROW_W'(ROWS_SHORT - 1);
  localparam logic [CNT_W-1:0] END_LONG   = CNT_W'(DWELL_LONG - 1);
  localparam logic [CNT_W-1:0] END_SHORT  = CNT_W'(DWELL_SHORT - 1);

  scan_mode_e mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= SCAN_ROWS16;
    else if (frame_wrap) mode_q <= pick_mode(two_line, tall_font);
  end

  always_comb begin
    unique case (mode_q)
      SCAN_ROWS16: begin rows_m1 = LAST_2L;    dwell_m1 = END_SHORT; end
      SCAN_ROWS11: begin rows_m1 = LAST_TALL;  dwell_m1 = END_LONG;  end
      default:     begin rows_m1 = LAST_SHORT; dwell_m1 = END_LONG;  end
    endcase
  end

  // Mode may only move on the last clock of a frame.
  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(mode_q));

endmodule

// File: rtl/lcd_scan_counter.sv
module lcd_scan_counter #(
  parameter int ROW_W = 4,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] rows_m1,
  input  logic [CNT_W-1:0] dwell_m1,
  output logic [ROW_W-1:0] row,
  output logic [CNT_W-1:0] cnt,
  output logic             row_end,
  output logic             frame_wrap,
  output logic             frame_start
);

  assign row_end     = (cnt == dwell_m1);
  assign frame_wrap  = row_end && (row == rows_m1);
  assign frame_start = (row == '0) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      row <= '0;
    end else if (row_end) begin
      cnt <= '0;
      row <= frame_wrap ? '0 : row + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= dwell_m1);

  assert_row_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    row <= rows_m1);

  assert_frame_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

endmodule

// File: rtl/lcd_com_decode.sv
module lcd_com_decode #(
  parameter int ROWS  = 16,
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_en,
  input  logic [ROW_W-1:0] row,
  output logic [ROWS-1:0]  com_sel
);

  for (genvar i = 0; i < ROWS; i++) begin : g_com
    assign com_sel[i] = disp_en && (row == ROW_W'(i));
  end

  assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com_sel));

  assert_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> (com_sel != '0));

endmodule

// File: rtl/lcd_seg_strobe.sv
module lcd_seg_strobe #(
  parameter int SEG_BITS = 40,
  parameter int CNT_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             row_end,
  output logic             shift_clk,
  output logic             latch_stb
);

  localparam logic [CNT_W-1:0] SHIFT_END = CNT_W'(2 * SEG_BITS);

  // Odd counts of the burst window carry the pulse, so each bit sees a low then high phase.
  assign shift_clk = (cnt < SHIFT_END) && cnt[0];
  assign latch_stb = row_end;

  assert_shift_alt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_clk |=> !shift_clk);

  assert_latch_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> (cnt == '0));

  assert_latch_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |-> !shift_clk);

endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int SEG_BITS    = 40,
  parameter int ROWS_2L     = 16,
  parameter int ROWS_TALL   = 11,
  parameter int ROWS_SHORT  = 8,
  parameter int DWELL_LONG  = 400,
  parameter int DWELL_SHORT = 200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               disp_en,
  input  logic               two_line,
  input  logic               tall_font,
  output logic [ROWS_2L-1:0] com_sel,
  output logic               shift_clk,
  output logic               latch_stb,
  output logic               alt_pol,
  output logic               frame_start
);

  localparam int DWELL_MAX = (DWELL_LONG > DWELL_SHORT) ? DWELL_LONG : DWELL_SHORT;
  localparam int ROW_W     = $clog2(ROWS_2L);
  localparam int CNT_W     = $clog2(DWELL_MAX + 1);

  logic [ROW_W-1:0] rows_m1;
  logic [CNT_W-1:0] dwell_m1;
  logic [ROW_W-1:0] row;
  logic [CNT_W-1:0] cnt;
  logic             row_end;
  logic             frame_wrap;

  lcd_scan_mode #(
    .ROWS_2L    (ROWS_2L),
    .ROWS_TALL  (ROWS_TALL),
    .ROWS_SHORT (ROWS_SHORT),
    .DWELL_LONG (DWELL_LONG),
    .DWELL_SHORT(DWELL_SHORT),
    .ROW_W      (ROW_W),
    .CNT_W      (CNT_W)
  ) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .two_line  (two_line),
    .tall_font (tall_font),
    .frame_wrap(frame_wrap),
    .rows_m1   (rows_m1),
    .dwell_m1  (dwell_m1)
  );

  lcd_scan_counter #(
    .ROW_W(ROW_W),
    .CNT_W(CNT_W)
  ) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .rows_m1    (rows_m1),
    .dwell_m1   (dwell_m1),
    .row        (row),
    .cnt        (cnt),
    .row_end    (row_end),
    .frame_wrap (frame_wrap),
    .frame_start(frame_start)
  );

  lcd_com_decode #(
    .ROWS (ROWS_2L),
    .ROW_W(ROW_W)
  ) u_com (
    .clk    (clk),
    .rst_n  (rst_n),
    .disp_en(disp_en),
    .row    (row),
    .com_sel(com_sel)
  );

  lcd_seg_strobe #(
    .SEG_BITS(SEG_BITS),
    .CNT_W   (CNT_W)
  ) u_seg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt),
    .row_end  (row_end),
    .shift_clk(shift_clk),
    .latch_stb(latch_stb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          alt_pol <= 1'b0;
    else if (frame_wrap) alt_pol <= ~alt_pol;
  end

  // Polarity only flips as a new frame opens.
  assert_alt_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alt_pol) |-> frame_start);

endmodule

// File: tb/lcd_scan_timer_tb.sv
`timescale 1ns/1ps
module lcd_scan_timer_tb;

  localparam int SEG  = 6;
  localparam int DL   = 40;
  localparam int DS   = 20;
  localparam int NCOM = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            disp_en = 1'b1;
  logic            two_line = 1'b1;
  logic            tall_font = 1'b0;
  logic [NCOM-1:0] com_sel;
  logic            shift_clk, latch_stb, alt_pol, frame_start;

  int total = 0;
  int bad   = 0;

  // Reference scan position
  int m_rows  = 16;
  int m_dwell = DS;
  int m_row   = 0;
  int m_cnt   = 0;
  bit m_alt   = 1'b0;

  always #5 clk = ~clk;

  lcd_scan_timer #(
    .SEG_BITS   (SEG),
    .ROWS_2L    (NCOM),
    .ROWS_TALL  (11),
    .ROWS_SHORT (8),
    .DWELL_LONG (DL),
    .DWELL_SHORT(DS)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_en    (disp_en),
    .two_line   (two_line),
    .tall_font  (tall_font),
    .com_sel    (com_sel),
    .shift_clk  (shift_clk),
    .latch_stb  (latch_stb),
    .alt_pol    (alt_pol),
    .frame_start(frame_start)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (row %0d cnt %0d)", tag, act, exp, m_row, m_cnt);
    end
  endtask

  task automatic compare_all(input string mode_tag);
    logic [NCOM-1:0] exp_com;
    exp_com = disp_en ? (NCOM'(1) << m_row) : '0;
    chk({mode_tag, " R4 com_sel"}, com_sel, exp_com);
    chk("R6 shift_clk", shift_clk, (m_cnt < 2*SEG) && (m_cnt % 2 == 1));
    chk("R7 latch_stb", latch_stb, m_cnt == m_dwell - 1);
    chk("R8 frame_start", frame_start, (m_row == 0) && (m_cnt == 0));
    chk("R9 alt_pol", alt_pol, m_alt);
  endtask

  // One clock: advance the model with the inputs present at the edge, compare at negedge.
  task automatic step(input string mode_tag);
    @(posedge clk);
    if (m_cnt == m_dwell - 1) begin
      m_cnt = 0;
      if (m_row == m_rows - 1) begin
        m_row = 0;
        m_alt = ~m_alt;
        if (two_line)       begin m_rows = 16; m_dwell = DS; end
        else if (tall_font) begin m_rows = 11; m_dwell = DL; end
        else                begin m_rows = 8;  m_dwell = DL; end
      end else begin
        m_row++;
      end
    end else begin
      m_cnt++;
    end
    @(negedge clk);
    compare_all(mode_tag);
  endtask

  task automatic wait_frame(input string tag);
    int n = 0;
    do begin step(tag); n++; end while (!frame_start && n < 2000);
  endtask

  task automatic measure_frame(input string tag, input int exp_len);
    int n = 0;
    do begin step(tag); n++; end while (!frame_start && n < 2000);
    chk({tag, " frame length"}, n, exp_len);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11: row 0 count 0, 16-row mode, polarity 0
    chk("R11 reset com_sel", com_sel, 1);
    chk("R11 reset frame_start", frame_start, 1);
    chk("R11 reset alt_pol", alt_pol, 0);
    chk("R11 reset latch_stb", latch_stb, 0);
    chk("R11 reset shift_clk", shift_clk, 0);
    rst_n = 1'b1;
    // First frame runs in the 16-row mode whatever the inputs say
    repeat (DS) step("R11");
    chk("R11 row1 after one short dwell", com_sel, 2);
  endtask

  task automatic t_two_line();
    two_line  = 1'b1;
    tall_font = 1'b1;   // R1: font ignored in two-line mode
    wait_frame("R1");
    measure_frame("R1", 16 * DS);
    measure_frame("R1", 16 * DS);
  endtask

  task automatic t_midframe();
    bit saw_top = 1'b0;
    repeat (50) step("R10");
    two_line  = 1'b0;
    tall_font = 1'b1;
    do begin
      step("R10");
      if (com_sel[15]) saw_top = 1'b1;
    end while (!frame_start);
    chk("R10 old frame still reached row 15", saw_top, 1);
    chk("R10 new frame starts at row 0", com_sel, 1);
    measure_frame("R10", 11 * DL);
  endtask

  task automatic t_one_line_tall();
    two_line  = 1'b0;
    tall_font = 1'b1;
    measure_frame("R3", 11 * DL);
  endtask

  task automatic t_one_line_short();
    two_line  = 1'b0;
    tall_font = 1'b0;
    wait_frame("R2");
    measure_frame("R2", 8 * DL);
    measure_frame("R2", 8 * DL);
  endtask

  task automatic t_display_off();
    repeat (17) step("R5");
    disp_en = 1'b0;
    #1;
    chk("R5 blank same cycle", com_sel, 0);
    repeat (90) step("R5");
    chk("R5 blank while off", com_sel, 0);
    disp_en = 1'b1;
    #1;
    chk("R5 resumes at model row", com_sel, NCOM'(1) << m_row);
    wait_frame("R5");
    two_line = 1'b1;
    wait_frame("R1");
    measure_frame("R1", 16 * DS);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_two_line();
    t_midframe();
    t_one_line_tall();
    t_one_line_short();
    t_display_off();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule